// File: doc/BRIEF.md
# Address Filter Setup Frame Builder

This block produces the fixed-size configuration frame that loads a station address into the perfect-address filter of an Ethernet transmit path. A one-cycle start pulse captures a 48-bit station address. The block then streams 192 bytes over a valid/ready byte interface. The six address bytes are packed in pairs into the low half of the first three 32-bit slots. Every other byte is 0xFF.

While a frame is in flight, the block presents a descriptor to the transmit path. The descriptor marks the transfer as a setup frame, sets the end-of-ring flag and gives the length as 192. After the last byte, the block waits for the transmit path to return a 32-bit completion status. The only status it accepts as clean is 0x7FFFFFFF. It then pulses `done` and reports whether the status was an error.

Top module: `setup_frame_gen`

## Requirements
- R1: After reset, `busy`, `out_valid`, `out_last`, `done`, `err`, `desc_setup` and `desc_eor` are all 0, and `desc_len` is 0.
- R2: Each frame is exactly 192 accepted bytes. `out_last` is 1 on the byte with offset 191 and only on that byte.
- R3: Address byte k is `station_addr[8k+7:8k]`. Bytes 0 and 1 appear at offsets 0 and 1, bytes 2 and 3 at offsets 4 and 5, and bytes 4 and 5 at offsets 8 and 9.
- R4: Every offset that does not carry an address byte holds 0xFF.
- R5: A byte moves on a cycle where `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` stay unchanged, and no byte is lost or repeated.
- R6: While `busy` is 1, the descriptor reads as follows: `desc_setup`=1, `desc_eor`=1 and `desc_len`=192. While idle, all three are 0.
- R7: After the last byte is accepted, `out_valid` drops and the block waits for `status_valid`. On the cycle after `status_valid`, `done` is high for exactly one cycle and `busy` falls. At that point `err` is 1 exactly when `status_word` differs from 0x7FFFFFFF, and `err` holds that value until the next accepted start.
- R8: The station address is sampled only on an accepted start. A start while `busy` is 1 is ignored and does not alter the frame in progress.
- R9: `status_valid` is ignored while bytes are still being sent or while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; accepted only when idle |
| station_addr | input | 48 | Station address; byte k in bits 8k+7:8k |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Downstream accepts byte |
| out_last | output | 1 | Marks byte 191 |
| desc_setup | output | 1 | Setup-frame flag to transmit path |
| desc_eor | output | 1 | End-of-ring flag to transmit path |
| desc_len | output | 8 | Frame length to transmit path |
| status_valid | input | 1 | Completion status strobe |
| status_word | input | 32 | Completion status value |
| busy | output | 1 | Frame or status check in progress |
| done | output | 1 | One-cycle pulse after status accepted |
| err | output | 1 | Last status was not 0x7FFFFFFF |

## Verification
Several frames are compared byte by byte against an arithmetic model. The addresses include all zeros, all ones and distinct byte values, so a swapped pair, a wrong slot stride or a leak into the high half of a slot shows up as a mismatched byte. Downstream stalls follow several periodic patterns; a design that advanced on `out_valid` alone would skip bytes and miss the last marker at offset 191.

During one frame, a second start carrying a different address and an early status strobe are injected. A design that relatched the address would corrupt later bytes, and one that took the early status would finish before sending the whole frame. Status words one bit away from the clean value, on either side, must set the error flag.

// File: rtl/setup_frame_gen.sv
module setup_frame_gen #(
  parameter int FRAME_LEN = 192,
  parameter int LEN_W = $clog2(FRAME_LEN + 1),
  parameter logic [31:0] STATUS_OK = 32'h7FFF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [47:0]      station_addr,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_last,
  output logic             desc_setup,
  output logic             desc_eor,
  output logic [LEN_W-1:0] desc_len,
  input  logic             status_valid,
  input  logic [31:0]      status_word,
  output logic             busy,
  output logic             done,
  output logic             err
);
  typedef enum logic [1:0] {IDLE, SEND, WAIT} st_t;

  localparam int ADDR_SPAN = 12;

  st_t              st;
  logic [LEN_W-1:0] idx;
  logic [47:0]      addr_q;
  logic [2:0]       bsel;
  logic             in_addr;
  logic             xfer;

  assign bsel     = {idx[3:2], idx[0]};
  assign in_addr  = (idx < LEN_W'(ADDR_SPAN)) && !idx[1];
  assign out_data = in_addr ? addr_q[{bsel, 3'b000} +: 8] : 8'hFF;

  assign out_valid  = (st == SEND);
  assign out_last   = out_valid && (idx == LEN_W'(FRAME_LEN - 1));
  assign xfer       = out_valid && out_ready;
  assign busy       = (st != IDLE);
  assign desc_setup = busy;
  assign desc_eor   = busy;
  assign desc_len   = busy ? LEN_W'(FRAME_LEN) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      idx    <= '0;
      addr_q <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          addr_q <= station_addr;
          idx    <= '0;
          err    <= 1'b0;
          st     <= SEND;
        end
        SEND: if (xfer) begin
          if (out_last) st <= WAIT;
          else          idx <= idx + 1'b1;
        end
        WAIT: if (status_valid) begin
          err  <= (status_word != STATUS_OK);
          done <= 1'b1;
          st   <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/setup_frame_gen_chk.sv
module setup_frame_gen_chk #(
  parameter int FRAME_LEN = 192,
  parameter int LEN_W = $clog2(FRAME_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       out_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_last,
  input logic             desc_setup,
  input logic             desc_eor,
  input logic [LEN_W-1:0] desc_len,
  input logic             busy,
  input logic             done
);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R2
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R6
  desc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (desc_setup && desc_eor && desc_len == LEN_W'(FRAME_LEN)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !desc_setup && !desc_eor));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind setup_frame_gen setup_frame_gen_chk #(.FRAME_LEN(FRAME_LEN), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_data(out_data), .out_valid(out_valid),
  .out_ready(out_ready), .out_last(out_last), .desc_setup(desc_setup),
  .desc_eor(desc_eor), .desc_len(desc_len), .busy(busy), .done(done));

// File: tb/setup_frame_gen_test.sv
module setup_frame_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 192;
  localparam logic [31:0] OK = 32'h7FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [47:0] station_addr = '0;
  logic [7:0]  out_data;
  logic        out_valid, out_ready = 1'b0, out_last;
  logic        desc_setup, desc_eor;
  logic [7:0]  desc_len;
  logic        status_valid = 1'b0;
  logic [31:0] status_word = '0;
  logic        busy, done, err;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  setup_frame_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .station_addr(station_addr),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .desc_setup(desc_setup), .desc_eor(desc_eor),
    .desc_len(desc_len), .status_valid(status_valid), .status_word(status_word),
    .busy(busy), .done(done), .err(err));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [47:0] a, input int i);
    if (i < 12 && (i % 4) < 2) return 8'((a >> (8 * ((i / 4) * 2 + (i % 2)))) & 48'hFF);
    return 8'hFF;
  endfunction

  function automatic bit rdy(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return (cyc % 2) == 1;
      default: return (cyc % 3) == 0;
    endcase
  endfunction

  task automatic run_frame(input logic [47:0] a, input int mode, input logic [31:0] sw, input bit poke);
    int cnt = 0;
    int cyc = 0;
    logic [7:0] e;
    @(negedge clk);
    station_addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0; station_addr = ~a;
    #1;
    chk(busy == 1'b1, "R8 start accepted busy", 64'(busy), 1);
    chk(desc_setup && desc_eor && desc_len == 8'(LEN), "R6 descriptor", {desc_setup, desc_eor, desc_len}, {1'b1, 1'b1, 8'(LEN)});
    while (cnt < LEN && cyc < 2000) begin
      out_ready = rdy(mode, cyc);
      start = poke && (cyc == 5);
      status_valid = poke && (cyc == 7);
      status_word = 32'h0;
      #1;
      if (out_valid && out_ready) begin
        e = exp_byte(a, cnt);
        if (e == 8'hFF) chk(out_data == e, "R4 fill byte", 64'(out_data), 64'(e));
        else            chk(out_data == e, "R3 address byte", 64'(out_data), 64'(e));
        chk(out_last == (cnt == LEN - 1), "R2 last marker", 64'(out_last), 64'(cnt == LEN - 1));
        cnt++;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; status_valid = 1'b0; out_ready = 1'b0;
    if (poke) chk(cnt == LEN, "R9 R5 full frame despite early status", 64'(cnt), LEN);
    #1;
    chk(!out_valid && busy && !done, "R7 waiting for status", {out_valid, busy, done}, 3'b010);
    @(negedge clk);
    chk(!done && busy, "R7 still waiting", {done, busy}, 2'b01);
    status_valid = 1'b1; status_word = sw;
    @(negedge clk);
    status_valid = 1'b0;
    #1;
    chk(done == 1'b1, "R7 done pulse", 64'(done), 1);
    chk(err == (sw != OK), "R7 err value", 64'(err), 64'(sw != OK));
    chk(!busy && !desc_setup && desc_len == 0, "R6 idle descriptor", {busy, desc_setup, desc_len}, 0);
    @(negedge clk);
    status_valid = 1'b1; status_word = OK ^ 32'h1;
    #1;
    chk(done == 1'b0, "R7 done single cycle", 64'(done), 0);
    @(negedge clk);
    status_valid = 1'b0;
    #1;
    chk(!done && err == (sw != OK), "R9 idle status ignored, err held", {done, err}, {1'b0, sw != OK});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk({busy, out_valid, out_last, done, err, desc_setup, desc_eor} == 0 && desc_len == 0,
        "R1 reset state", {busy, out_valid, out_last, done, err, desc_setup, desc_eor, desc_len}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_frame(48'h0123_4567_89AB, 0, OK, 1'b0);
    run_frame(48'hFFFF_FFFF_FFFF, 1, 32'h7FFF_FFFE, 1'b0);
    run_frame(48'h0000_0000_0000, 2, OK, 1'b0);
    run_frame(48'hA1B2_C3D4_E5F6, 2, 32'hFFFF_FFFF, 1'b1);
    run_frame(48'h0605_0403_0201, 1, OK, 1'b1);
    run_frame(48'h8000_0000_0001, 0, 32'h0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule